// File: doc/BRIEF.md
# Pulse Interval Constraint Monitor

This block watches the pulse strobes arriving on the input lines of a single pulse-driven cell and checks the time between them. Time is counted in clock cycles. For every ordered pair of lines (x, y), where y is the line whose pulse follows a pulse on x, a configuration field sets one of three rules. The rule can be a minimum spacing, a maximum spacing, or no rule. A same-line pair (x, x) can carry a rule as well. Any mix of rules can be loaded, so one instance covers very different cells. One example is a clocked gate whose data and clock lines must stay apart. Another is a merging buffer whose two inputs must arrive close together so that they merge into one output pulse.

Each line has a saturating age counter that records how many cycles have passed since its last pulse. Every ordered pair has its own checker. For a maximum rule, that checker runs a two-state machine that tracks an open window. When a rule is broken, the block raises a one-cycle flag and reports the pair's index. It also sets a summary bit that stays set until it is cleared.

Top module: `pim_monitor`

Each pair checker has the states PS_IDLE and PS_WAIT. The transitions are:
- *open*: PS_IDLE to PS_WAIT. An armed pulse on x arrives under a maximum rule, and no y pulse arrives in the same cycle (for x different from y).
- *satisfy*: PS_WAIT to PS_IDLE. A y pulse arrives within the limit.
- *expire*: PS_WAIT to PS_IDLE. The interval exceeds the limit, and a violation is reported.
- *restart*: PS_WAIT to PS_WAIT. A new armed x pulse arrives.
- *cancel*: PS_WAIT to PS_IDLE. An unarmed x pulse arrives.
- *disable*: any state to PS_IDLE. The rule is no longer a maximum rule.

## Requirements
- R1: While rst_n is low, and after it is released, viol_flag, viol_pair and viol_sticky are 0. No pulse seen before reset counts as history, so the first pulse on a line after reset never breaks a minimum rule that starts from that line.
- R2: Pair (x, y) has index p = x*NUM_IN + y. Its rule kind sits in cfg_kind[2p+1:2p], coded 0 = none, 1 = minimum, 2 = maximum and 3 = none. Its limit sits in cfg_lim[TW*p +: TW]. The reported viol_pair is p.
- R3: Under a minimum rule, a y pulse whose interval d is below the limit is a violation. The interval d is the number of clock edges from the latest x pulse to the y pulse. Pulses on two different lines in the same cycle give d = 0. For a same-line pair, d is measured from the previous pulse on that line.
- R4: Under a maximum rule, an x pulse with arm_in[x] high opens a window measured from that pulse. A y pulse with d no greater than the limit closes the window without a violation. When d reaches limit+1 with the window still open, one violation is reported and the window closes. A later x pulse inside the window restarts the window if it is armed, and cancels the window if it is not.
- R5: An unarmed x pulse never produces a maximum violation. A pair with rule kind none (code 0 or 3) never produces a violation.
- R6: viol_flag is high in exactly the cycle after the clock edge at which a violation is detected. viol_pair is valid in that same cycle.
- R7: When several pairs break their rules at the same edge, the lowest pair index is reported.
- R8: viol_sticky is set by any violation and stays set until sticky_clr is sampled high. A violation at the same edge as a clear leaves viol_sticky set.
- R9: Each line's age counter saturates rather than wraps. A minimum rule with limit 255 (TW = 8) therefore holds after a gap of 300 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one time tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_in | input | NUM_IN | One-cycle pulse strobe for each line |
| arm_in | input | NUM_IN | Partner-expected qualifier for each line, sampled with that line's pulse |
| cfg_kind | input | 2*NUM_IN*NUM_IN | Rule kind for each ordered pair |
| cfg_lim | input | TW*NUM_IN*NUM_IN | Interval limit for each ordered pair, in cycles |
| sticky_clr | input | 1 | Clears the summary bit |
| viol_flag | output | 1 | One-cycle violation strobe |
| viol_pair | output | clog2(NUM_IN*NUM_IN) | Index of the violated pair |
| viol_sticky | output | 1 | Summary bit, set on any violation |

## Verification
The embedded assertions check the following on every cycle:
- the age counters restart and saturate correctly;
- a window opens only from an armed pulse;
- a pair whose rule is not a maximum rule drops back to idle;
- a reported index is always in range;
- the summary bit agrees with the flag and holds until cleared.

Other behaviour can only be shown by the bench's scenarios:
- the exact interval arithmetic, including pulses on two lines in the same cycle and same-line spacing;
- expiry of a window at precisely limit+1;
- priority among several violations at the same edge;
- saturation after a long quiet gap.

// File: rtl/pim_pkg.sv
package pim_pkg;

    // Rule kind for one ordered input pair
    typedef enum logic [1:0] {
        CK_NONE = 2'd0,
        CK_MIN  = 2'd1,
        CK_MAX  = 2'd2,
        CK_RSVD = 2'd3
    } cons_kind_e;

    // Window tracker state for maximum-spacing rules
    typedef enum logic {
        PS_IDLE = 1'b0,
        PS_WAIT = 1'b1
    } pair_state_e;

endpackage

// File: rtl/pim_age.sv
module pim_age #(
    parameter int NUM_IN = 3,
    parameter int TW     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_IN-1:0]    pulse,
    output logic [NUM_IN*TW-1:0] age_flat,
    output logic [NUM_IN-1:0]    seen
);
    localparam logic [TW-1:0] AGE_TOP = {TW{1'b1}};

    for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_line
        logic [TW-1:0] age_q;
        logic          seen_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                age_q  <= '0;
                seen_q <= 1'b0;
            end else if (pulse[gi]) begin
                age_q  <= '0;
                seen_q <= 1'b1;
            end else if (age_q != AGE_TOP) begin
                age_q  <= age_q + 1'b1;
            end
        end

        assign age_flat[gi*TW +: TW] = age_q;
        assign seen[gi]              = seen_q;

        // R9: a saturated counter stays saturated while the line is quiet
        a_r9_age_saturates: assert property (@(posedge clk) disable iff (!rst_n)
            (age_q == AGE_TOP && !pulse[gi]) |=> (age_q == AGE_TOP));
        // R3: a pulse restarts the age count and marks the line as seen
        a_r3_age_restart: assert property (@(posedge clk) disable iff (!rst_n)
            pulse[gi] |=> (age_q == '0 && seen_q));
    end
endmodule

// File: rtl/pim_pair.sv
module pim_pair
    import pim_pkg::*;
#(
    parameter int TW   = 8,
    parameter bit SELF = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          x_pulse,
    input  logic          x_arm,
    input  logic          y_pulse,
    input  logic [TW-1:0] x_age,
    input  logic          x_seen,
    input  logic [1:0]    kind,
    input  logic [TW-1:0] lim,
    output logic          hit
);
    pair_state_e   state_q, state_d;
    logic [TW:0]   d_prev, d_now, lim_ext;
    logic          is_min, is_max, min_hit, exp_hit, open_ok, history;

    assign is_min  = (kind == CK_MIN);
    assign is_max  = (kind == CK_MAX);
    assign lim_ext = {1'b0, lim};
    assign d_prev  = {1'b0, x_age} + {{TW{1'b0}}, 1'b1};
    assign d_now   = (!SELF && x_pulse) ? '0 : d_prev;
    assign history = SELF ? x_seen : (x_pulse || x_seen);
    assign open_ok = x_pulse && x_arm && (SELF || !y_pulse);

    assign min_hit = is_min && y_pulse && history && (d_now < lim_ext);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_IDLE;
        else        state_q <= state_d;
    end

    // Next state and expiry detection
    always_comb begin
        state_d = state_q;
        exp_hit = 1'b0;
        unique case (state_q)
            PS_IDLE: begin
                if (is_max && open_ok) state_d = PS_WAIT;
            end
            PS_WAIT: begin
                if (!is_max) begin
                    state_d = PS_IDLE;
                end else begin
                    exp_hit = (d_prev > lim_ext);
                    if (x_pulse)                  state_d = open_ok ? PS_WAIT : PS_IDLE;
                    else if (exp_hit || y_pulse)  state_d = PS_IDLE;
                end
            end
            default: state_d = PS_IDLE;
        endcase
    end

    assign hit = min_hit || exp_hit;

    // R4: a window only opens from an armed pulse on x
    a_r4_open_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == PS_WAIT) |-> $past(x_pulse && x_arm));
    // R5: without a maximum rule the tracker returns to idle
    a_r5_non_max_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != CK_MAX) |=> (state_q == PS_IDLE));
endmodule

// File: rtl/pim_report.sv
module pim_report #(
    parameter int NPAIR = 9,
    parameter int PW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPAIR-1:0] hit,
    input  logic             sticky_clr,
    output logic             viol_flag,
    output logic [PW-1:0]    viol_pair,
    output logic             viol_sticky
);
    logic [PW-1:0] first_idx;
    logic          any_hit;

    assign any_hit = |hit;

    // Lowest index wins: scan downward so the last assignment is the lowest
    always_comb begin
        first_idx = '0;
        for (int i = NPAIR - 1; i >= 0; i--) begin
            if (hit[i]) first_idx = PW'(i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            viol_flag   <= 1'b0;
            viol_pair   <= '0;
            viol_sticky <= 1'b0;
        end else begin
            viol_flag <= any_hit;
            if (any_hit)         viol_pair <= first_idx;
            else                 viol_pair <= '0;
            if (any_hit)         viol_sticky <= 1'b1;
            else if (sticky_clr) viol_sticky <= 1'b0;
        end
    end

    // R8: every reported violation is reflected in the summary bit
    a_r8_flag_sets_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        viol_flag |-> viol_sticky);
    // R8: the summary bit holds without a clear
    a_r8_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_sticky && !sticky_clr) |=> viol_sticky);
    // R2: a reported index names an existing pair
    a_r2_pair_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        viol_flag |-> (int'(viol_pair) < NPAIR));
    // R6: the flag follows a pair hit by exactly one edge
    a_r6_flag_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |=> viol_flag);
endmodule

// File: rtl/pim_monitor.sv
module pim_monitor
    import pim_pkg::*;
#(
    parameter int NUM_IN = 3,
    parameter int TW     = 8,
    localparam int NPAIR = NUM_IN * NUM_IN,
    localparam int PW    = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_IN-1:0]   pulse_in,
    input  logic [NUM_IN-1:0]   arm_in,
    input  logic [2*NPAIR-1:0]  cfg_kind,
    input  logic [TW*NPAIR-1:0] cfg_lim,
    input  logic                sticky_clr,
    output logic                viol_flag,
    output logic [PW-1:0]       viol_pair,
    output logic                viol_sticky
);
    logic [NUM_IN*TW-1:0] age_flat;
    logic [NUM_IN-1:0]    seen;
    logic [NPAIR-1:0]     hit;

    pim_age #(.NUM_IN(NUM_IN), .TW(TW)) u_age (
        .clk      (clk),
        .rst_n    (rst_n),
        .pulse    (pulse_in),
        .age_flat (age_flat),
        .seen     (seen)
    );

    for (genvar gx = 0; gx < NUM_IN; gx++) begin : g_x
        for (genvar gy = 0; gy < NUM_IN; gy++) begin : g_y
            localparam int P = gx * NUM_IN + gy;
            pim_pair #(.TW(TW), .SELF(gx == gy)) u_pair (
                .clk     (clk),
                .rst_n   (rst_n),
                .x_pulse (pulse_in[gx]),
                .x_arm   (arm_in[gx]),
                .y_pulse (pulse_in[gy]),
                .x_age   (age_flat[gx*TW +: TW]),
                .x_seen  (seen[gx]),
                .kind    (cfg_kind[2*P +: 2]),
                .lim     (cfg_lim[TW*P +: TW]),
                .hit     (hit[P])
            );
        end
    end

    pim_report #(.NPAIR(NPAIR), .PW(PW)) u_report (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit         (hit),
        .sticky_clr  (sticky_clr),
        .viol_flag   (viol_flag),
        .viol_pair   (viol_pair),
        .viol_sticky (viol_sticky)
    );
endmodule

// File: tb/tb_pim_monitor.sv
module tb_pim_monitor;
    localparam int N  = 3;
    localparam int TW = 8;
    localparam int NP = N * N;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    pulse_in = '0;
    logic [N-1:0]    arm_in = '0;
    logic [2*NP-1:0] cfg_kind = '0;
    logic [TW*NP-1:0] cfg_lim = '0;
    logic            sticky_clr = 1'b0;
    logic            viol_flag;
    logic [3:0]      viol_pair;
    logic            viol_sticky;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    pim_monitor #(.NUM_IN(N), .TW(TW)) dut (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .arm_in(arm_in),
        .cfg_kind(cfg_kind), .cfg_lim(cfg_lim), .sticky_clr(sticky_clr),
        .viol_flag(viol_flag), .viol_pair(viol_pair), .viol_sticky(viol_sticky)
    );

    // Table: {pulse[2:0], expected flag, expected pair[3:0]} per cycle
    localparam logic [7:0] TBL [0:13] = '{
        8'b001_0_0000, 8'b000_0_0000, 8'b000_0_0000, 8'b100_0_0000,
        8'b001_1_0110, 8'b010_1_0111, 8'b000_0_0000, 8'b011_1_0100,
        8'b100_1_0010, 8'b000_0_0000, 8'b000_0_0000, 8'b100_0_0000,
        8'b100_1_1000, 8'b101_1_0010
    };

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    // Called at a falling edge; returns at the next falling edge
    task automatic drive(logic [N-1:0] p, logic [N-1:0] a, logic c);
        pulse_in = p; arm_in = a; sticky_clr = c;
        @(posedge clk);
        @(negedge clk);
        pulse_in = '0; arm_in = '0; sticky_clr = 1'b0;
    endtask

    task automatic quiet(int n, string req);
        for (int i = 0; i < n; i++) begin
            drive('0, '0, 1'b0);
            check(req, viol_flag, 0);
        end
    endtask

    task automatic set_rule(int x, int y, logic [1:0] k, logic [TW-1:0] l);
        cfg_kind[2*(x*N+y) +: 2]   = k;
        cfg_lim[TW*(x*N+y) +: TW]  = l;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic profile_clocked();
        cfg_kind = '0; cfg_lim = '0;
        for (int x = 0; x < N; x++)
            for (int y = 0; y < N; y++)
                if (!((x == 0 && y == 1) || (x == 1 && y == 0))) set_rule(x, y, 2'd1, 8'd3);
    endtask

    task automatic profile_merge();
        cfg_kind = '0; cfg_lim = '0;
        set_rule(0, 0, 2'd1, 8'd2);
        set_rule(1, 1, 2'd1, 8'd2);
        set_rule(0, 1, 2'd2, 8'd4);
        set_rule(1, 0, 2'd2, 8'd4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL R6 watchdog act=running exp=finished");
            finish_run();
        end
    end

    initial begin
        // R1: state held in reset
        repeat (2) @(negedge clk);
        check("R1 flag in reset", viol_flag, 0);
        check("R1 pair in reset", viol_pair, 0);
        check("R1 sticky in reset", viol_sticky, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R6 R7: clocked-gate profile, minimum 3 on all but (0,1)/(1,0)
        profile_clocked();
        for (int s = 0; s < 14; s++) begin
            drive(TBL[s][7:5], '0, 1'b0);
            check($sformatf("R3 table step %0d flag", s), viol_flag, int'(TBL[s][4]));
            if (TBL[s][4]) check($sformatf("R7 table step %0d pair", s), viol_pair, int'(TBL[s][3:0]));
        end

        // R8: sticky set, then cleared
        check("R8 sticky after table", viol_sticky, 1);
        drive('0, '0, 1'b1);
        check("R8 sticky cleared", viol_sticky, 0);
        check("R6 flag dropped", viol_flag, 0);
        // R8: violation at the same edge as clear keeps sticky
        drive(3'b100, '0, 1'b0);
        drive(3'b100, '0, 1'b1);
        check("R3 self pair spacing 1", viol_pair, 8);
        check("R8 set wins over clear", viol_sticky, 1);
        drive('0, '0, 1'b1);

        // R4: merge profile, partner inside window
        do_reset();
        profile_merge();
        drive(3'b001, 3'b001, 1'b0);
        quiet(3, "R4 window open");
        drive(3'b010, '0, 1'b0);
        check("R4 partner at limit", viol_flag, 0);
        quiet(8, "R4 closed window");
        check("R4 no sticky", viol_sticky, 0);

        // R4 R6: window expires at limit+1, exactly once
        drive(3'b001, 3'b001, 1'b0);
        quiet(4, "R4 before expiry");
        drive('0, '0, 1'b0);
        check("R4 expiry flag", viol_flag, 1);
        check("R4 expiry pair", viol_pair, 1);
        drive('0, '0, 1'b0);
        check("R6 single flag", viol_flag, 0);
        drive('0, '0, 1'b1);

        // R5: unarmed pulse never expires
        drive(3'b001, '0, 1'b0);
        quiet(8, "R5 unarmed");
        check("R5 unarmed sticky", viol_sticky, 0);

        // R4: simultaneous armed pulses satisfy both directions
        drive(3'b011, 3'b011, 1'b0);
        check("R4 simultaneous", viol_flag, 0);
        quiet(8, "R4 simultaneous window");
        check("R4 simultaneous sticky", viol_sticky, 0);

        // R3: same-line spacing 1 under minimum 2
        drive(3'b001, '0, 1'b0);
        drive(3'b001, '0, 1'b0);
        check("R3 self min flag", viol_flag, 1);
        check("R3 self min pair", viol_pair, 0);

        // R9: saturation across a 300-cycle gap
        do_reset();
        cfg_kind = '0; cfg_lim = '0;
        set_rule(0, 0, 2'd1, 8'd255);
        drive(3'b001, '0, 1'b0);
        repeat (300) drive('0, '0, 1'b0);
        drive(3'b001, '0, 1'b0);
        check("R9 saturated gap", viol_flag, 0);
        drive(3'b001, '0, 1'b0);
        check("R9 short gap flags", viol_flag, 1);

        // R1 R5: first pulse after reset has no history; code 3 is no rule
        do_reset();
        cfg_kind = '0; cfg_lim = '0;
        set_rule(0, 1, 2'd3, 8'd10);
        set_rule(1, 1, 2'd1, 8'd10);
        drive(3'b001, 3'b001, 1'b0);
        drive(3'b010, '0, 1'b0);
        check("R1 first pulse no history", viol_flag, 0);
        quiet(12, "R5 reserved code");
        check("R5 reserved sticky", viol_sticky, 0);

        finish_run();
    end
endmodule